// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block keeps the interrupt state of a serial port: an eleven-bit raw status word, an eleven-bit enable mask and the logic that clears raw bits. Event strobes from the receive path, the transmit path, the receive-timeout counter, the modem-status inputs and the error detectors set raw bits. Raw bits stay set until software clears them.

Software reaches the state through a small word-addressed register bus. It can write and read the mask. It can read the raw status and the masked status. It clears raw bits through a write-one-to-clear register. Six interrupt lines come from the masked status word. One line is the OR of every enabled bit, and the other five each serve one category of source. A neighbouring data-register decoder gives a strobe for each transmit-data write, and that strobe sets the transmit bit.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the mask and the raw status are zero, all six `irq_out` lines are low, and reads of offsets 0, 1 and 2 return 0.
- R2: A 1 on `evt_set[i]` in a cycle sets raw bit i, and that bit stays set until it is cleared. The bit layout is: 0 ring, 1 clear-to-send, 2 carrier, 3 data-set-ready, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun.
- R3: A 1 on `tx_wr_strobe` sets raw bit 5.
- R4: A write to offset 0 loads bits [10:0] of `reg_wdata` into the mask, and a read of offset 0 returns the mask.
- R5: A read of offset 1 returns the raw status. A read of offset 2 returns the raw status AND the mask.
- R6: A write to offset 3 clears each raw bit whose written bit is 1 and leaves every other raw bit unchanged. A read of offset 3 returns 0.
- R7: Writes to offsets 1 and 2 change neither the raw status nor the mask.
- R8: `irq_out[0]` is high when any bit of the masked status is 1.
- R9: `irq_out[1]` follows masked bit 4, `irq_out[2]` follows masked bit 5 and `irq_out[3]` follows masked bit 6. `irq_out[4]` is the OR of masked bits [3:0], and `irq_out[5]` is the OR of masked bits [10:7].
- R10: When an event sets a bit in the same cycle that a clear write targets that bit, the bit ends up set.
- R11: `irq_out` takes the new value in the cycle after the edge that registers an event, a mask write or a clear.
- R12: `reg_rdata` is updated one cycle after a read access and holds its value between reads. Offsets 4 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | DATA_W | Write data; bits [10:0] are used |
| reg_rdata | output | DATA_W | Read data, registered |
| evt_set | input | 11 | Per-bit event strobes |
| tx_wr_strobe | input | 1 | Transmit-data write strobe |
| irq_out | output | 6 | 0 combined, 1 receive, 2 transmit, 3 timeout, 4 modem, 5 error |

## Verification
The state sits in two registers and the lines depend only on those registers. A bad raw or mask bit therefore shows on `irq_out` one cycle after the edge that stored it, and it shows on the readback of offsets 0 to 2 one cycle after the read. The bench drives each source bit alone, so a bit that is routed to the wrong line stands out, and it drives an event in the same cycle as a clear to test the set-over-clear priority. A bad clear mask shows as raw bits left over after a partial clear.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NSRC  = 11;
    localparam int NLINE = 6;

    localparam int B_RI  = 0;
    localparam int B_CTS = 1;
    localparam int B_DCD = 2;
    localparam int B_DSR = 3;
    localparam int B_RX  = 4;
    localparam int B_TX  = 5;
    localparam int B_RT  = 6;
    localparam int B_FE  = 7;
    localparam int B_OE  = 10;

    localparam int OFS_MASK = 0;
    localparam int OFS_RAW  = 1;
    localparam int OFS_MIS  = 2;
    localparam int OFS_CLR  = 3;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t mask;
        src_vec_t raw;
    } irq_state_t;

    // Source bits that feed each output line
    function automatic src_vec_t line_group(input int line);
        src_vec_t g;
        g = '0;
        case (line)
            0: g = '1;
            1: g[B_RX] = 1'b1;
            2: g[B_TX] = 1'b1;
            3: g[B_RT] = 1'b1;
            4: for (int b = B_RI; b <= B_DSR; b++) g[b] = 1'b1;
            5: for (int b = B_FE; b <= B_OE; b++) g[b] = 1'b1;
            default: g = '0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/uirq_regif.sv
module uirq_regif
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  src_vec_t          mask_q,
    input  src_vec_t          raw_q,
    input  src_vec_t          masked,
    output logic              mask_we,
    output src_vec_t          mask_wval,
    output src_vec_t          clr_vec,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [DATA_W-1:0] rd_val;
    logic              wr_acc, rd_acc;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[DATA_W-1:NSRC];

    always_comb begin
        wr_acc    = reg_sel && reg_wr;
        rd_acc    = reg_sel && !reg_wr;
        mask_we   = wr_acc && (reg_addr == ADDR_W'(OFS_MASK));
        mask_wval = reg_wdata[NSRC-1:0];
        clr_vec   = (wr_acc && (reg_addr == ADDR_W'(OFS_CLR))) ? reg_wdata[NSRC-1:0] : '0;

        case (reg_addr)
            ADDR_W'(OFS_MASK): rd_val = DATA_W'(mask_q);
            ADDR_W'(OFS_RAW):  rd_val = DATA_W'(raw_q);
            ADDR_W'(OFS_MIS):  rd_val = DATA_W'(masked);
            default:           rd_val = '0;
        endcase

        rdata_d = rd_acc ? rd_val : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/uirq_status.sv
module uirq_status
    import uirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t evt_set,
    input  logic     tx_wr_strobe,
    input  logic     mask_we,
    input  src_vec_t mask_wval,
    input  src_vec_t clr_vec,
    output src_vec_t mask_q,
    output src_vec_t raw_q
);
    irq_state_t st_d, st_q;
    src_vec_t   set_vec;

    always_comb begin
        set_vec         = evt_set;
        set_vec[B_TX]   = evt_set[B_TX] | tx_wr_strobe;
        st_d            = st_q;
        // Set wins: clear first, then OR in the new events
        st_d.raw        = (st_q.raw & ~clr_vec) | set_vec;
        if (mask_we) st_d.mask = mask_wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;
    assign raw_q  = st_q.raw;
endmodule

// File: rtl/uirq_route.sv
module uirq_route
    import uirq_pkg::*;
(
    input  src_vec_t         raw_q,
    input  src_vec_t         mask_q,
    output src_vec_t         masked,
    output logic [NLINE-1:0] irq
);
    assign masked = raw_q & mask_q;

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        assign irq[g] = |(masked & line_group(g));
    end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   evt_set,
    input  logic              tx_wr_strobe,
    output logic [NLINE-1:0]  irq_out
);
    src_vec_t mask_q, raw_q, masked;
    src_vec_t mask_wval, clr_vec;
    logic     mask_we;

    uirq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mask_q    (mask_q),
        .raw_q     (raw_q),
        .masked    (masked),
        .mask_we   (mask_we),
        .mask_wval (mask_wval),
        .clr_vec   (clr_vec),
        .reg_rdata (reg_rdata)
    );

    uirq_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_set      (evt_set),
        .tx_wr_strobe (tx_wr_strobe),
        .mask_we      (mask_we),
        .mask_wval    (mask_wval),
        .clr_vec      (clr_vec),
        .mask_q       (mask_q),
        .raw_q        (raw_q)
    );

    uirq_route u_route (
        .raw_q  (raw_q),
        .mask_q (mask_q),
        .masked (masked),
        .irq    (irq_out)
    );
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NSRC-1:0]   wdata_lo,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NSRC-1:0]   evt_set,
    input logic              tx_wr_strobe,
    input logic [NLINE-1:0]  irq_out,
    input logic [NSRC-1:0]   raw_q,
    input logic [NSRC-1:0]   mask_q
);
    logic quiet;
    assign quiet = (evt_set == '0) && !tx_wr_strobe;

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((raw_q & $past(evt_set)) == $past(evt_set))); // R2

    AST_TX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_strobe |=> raw_q[B_TX]); // R3

    AST_CLEAR_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == ADDR_W'(OFS_CLR) && quiet)
        |=> ((raw_q & $past(wdata_lo)) == '0)); // R6

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr && reg_addr == ADDR_W'(OFS_CLR)) |=> (reg_rdata == '0)); // R6

    AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && (reg_addr == ADDR_W'(OFS_RAW) || reg_addr == ADDR_W'(OFS_MIS)) && quiet)
        |=> ($stable(raw_q) && $stable(mask_q))); // R7

    AST_COMBINED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[0] == ((raw_q & mask_q) != '0)); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == ADDR_W'(OFS_CLR) && (evt_set & wdata_lo) != '0)
        |=> ((raw_q & $past(evt_set)) == $past(evt_set))); // R10

    AST_MIS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr && reg_addr == ADDR_W'(OFS_MIS))
        |=> (reg_rdata == DATA_W'($past(raw_q & mask_q)))); // R5
endmodule

bind uirq_ctrl uirq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .wdata_lo     (reg_wdata[uirq_pkg::NSRC-1:0]),
    .reg_rdata    (reg_rdata),
    .evt_set      (evt_set),
    .tx_wr_strobe (tx_wr_strobe),
    .irq_out      (irq_out),
    .raw_q        (raw_q),
    .mask_q       (mask_q)
);

// File: tb/uirq_ctrl_test.sv
module uirq_ctrl_test;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_sel = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [10:0]   evt_set = '0;
    logic          tx_wr_strobe = 1'b0;
    logic [5:0]    irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uirq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_set(evt_set), .tx_wr_strobe(tx_wr_strobe), .irq_out(irq_out)
    );

    function automatic logic [5:0] exp_irq(input logic [10:0] m);
        logic [5:0] r;
        r[0] = |m;
        r[1] = m[4];
        r[2] = m[5];
        r[3] = m[6];
        r[4] = |m[3:0];
        r[5] = |m[10:7];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = AW'(a);
        @(negedge clk);
        d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic pulse(input logic [10:0] ev, input logic tx);
        @(negedge clk);
        evt_set = ev; tx_wr_strobe = tx;
        @(negedge clk);
        evt_set = '0; tx_wr_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq during reset", 32'(irq_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", 32'(irq_out), 32'h0);
        rd(0, d); check("R1 mask reset", d, 32'h0);
        rd(1, d); check("R1 raw reset", d, 32'h0);
        rd(2, d); check("R1 masked reset", d, 32'h0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        wr(0, 32'hFFFF_F5A5);
        rd(0, d); check("R4 mask readback", d, 32'h5A5);
        check("R4 no irq with empty raw", 32'(irq_out), 32'h0);
    endtask

    task automatic t_each_source();
        logic [31:0] d;
        wr(0, 32'h7FF);
        for (int i = 0; i < 11; i++) begin
            pulse(11'(1 << i), 1'b0);
            check($sformatf("R9 R11 lines for bit %0d", i), 32'(irq_out), 32'(exp_irq(11'(1 << i))));
            check($sformatf("R8 combined for bit %0d", i), 32'(irq_out[0]), 32'h1);
            rd(1, d); check($sformatf("R2 raw holds bit %0d", i), d, 32'(1 << i));
            wr(3, 32'(1 << i));
            check($sformatf("R6 lines clear bit %0d", i), 32'(irq_out), 32'h0);
        end
    endtask

    task automatic t_masking();
        logic [31:0] d;
        wr(0, 32'h0);
        pulse(11'h7FF, 1'b0);
        check("R5 all masked lines low", 32'(irq_out), 32'h0);
        rd(2, d); check("R5 masked read zero", d, 32'h0);
        rd(1, d); check("R5 raw read all", d, 32'h7FF);
        wr(0, 32'h0F0);
        check("R11 lines after mask write", 32'(irq_out), 32'(exp_irq(11'h0F0)));
        rd(2, d); check("R5 masked read", d, 32'h0F0);
        wr(3, 32'h0A0);
        rd(1, d); check("R6 partial clear", d, 32'h75F);
        check("R11 lines after clear", 32'(irq_out), 32'(exp_irq(11'h050)));
        rd(3, d); check("R6 clear reads zero", d, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        wr(1, 32'h0);
        wr(2, 32'h7FF);
        rd(1, d); check("R7 raw unchanged", d, 32'h75F);
        rd(0, d); check("R7 mask unchanged", d, 32'h0F0);
        check("R7 lines unchanged", 32'(irq_out), 32'(exp_irq(11'h050)));
    endtask

    task automatic t_tx();
        logic [31:0] d;
        wr(3, 32'h7FF);
        wr(0, 32'h7FF);
        pulse(11'h0, 1'b1);
        check("R3 tx line", 32'(irq_out), 32'(exp_irq(11'h020)));
        rd(1, d); check("R3 raw tx bit", d, 32'h020);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        evt_set = 11'h010; tx_wr_strobe = 1'b1;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = AW'(3); reg_wdata = 32'h7FF;
        @(negedge clk);
        evt_set = '0; tx_wr_strobe = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
        rd(1, d); check("R10 set beats clear", d, 32'h030);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        rd(5, d); check("R12 offset 5 zero", d, 32'h0);
        rd(1, d);
        pulse(11'h400, 1'b0);
        @(negedge clk);
        check("R12 rdata holds between reads", reg_rdata, 32'h030);
        rd(15, d); check("R12 offset 15 zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_mask_rw();
        t_each_source();
        t_masking();
        t_ignored();
        t_tx();
        t_set_wins();
        t_unused();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule